// File: doc/BRIEF.md
# Ramped FSK Tuning-Word Sweeper

This block produces the 48-bit tuning word that drives an NCO phase accumulator in a frequency-shift-keyed transmitter. It does not jump between the two keying frequencies. When the select pin changes, the word moves in a straight line between a low frequency and a high frequency. A frequency accumulator holds the offset above the low frequency. Each time a programmable step timer expires, the accumulator moves by a delta word: up while the select pin is high, down while it is low. The accumulator is clamped so that the word lands exactly on the low or high endpoint and stays there for as long as the pin holds.

Software programs the low endpoint, the high endpoint (which must not be below the low one), a positive delta and a step interval. Before the first sweep it pulses the clear control to zero the accumulator. The delta and the step interval may be rewritten while a sweep runs. Changing them piece by piece produces nonlinear, piecewise ramps. The ramp engine runs only while the mode input carries the ramped-keying code. In every other mode the accumulator and the timer are frozen.

Top module: `rfsk_sweeper`

## Requirements
- R1: While and after synchronous reset, with no step taken yet, `tune_word` equals `f_low`. The accumulator is zero and the step timer is at zero, so the first step comes on the first active cycle.
- R2: When `mode` is not 3'b010 and `clr_acc` is low, the accumulator and the step timer hold their values. `tune_word` stays `f_low` plus the held offset.
- R3: `clr_acc` high at a clock edge zeroes the accumulator, so `tune_word` equals `f_low` in the following cycle. It also loads the timer with its reload value. Clearing works in any mode.
- R4: In mode 3'b010, with `ramp_rate` = N and N ≥ 1, a step happens once every N clocks. With N = 0 a step happens every clock. The timer reloads to max(N,1)−1 after each step, and a step fires when it reads zero.
- R5: On a step with `fsk_sel` high, the offset grows by `delta_word`.
- R6: On a step with `fsk_sel` low, the offset shrinks by `delta_word`.
- R7: An upward step that would reach or pass `f_high − f_low` leaves `tune_word` exactly at `f_high`, and it stays there while `fsk_sel` remains high.
- R8: A downward step with `delta_word` ≥ the offset leaves `tune_word` exactly at `f_low`, and it stays there while `fsk_sel` remains low.
- R9: A new `delta_word` applies from the next step. A new `ramp_rate` applies from the next timer reload.
- R10: `tune_word` is `f_low` plus the accumulator offset, with no register in between, so a change of `f_low` shows in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 3 | Operating mode; 3'b010 enables the ramp |
| fsk_sel | input | 1 | Keying pin: high ramps toward f_high, low toward f_low |
| clr_acc | input | 1 | Clears the frequency accumulator |
| f_low | input | 48 | Low endpoint tuning word |
| f_high | input | 48 | High endpoint tuning word (≥ f_low) |
| delta_word | input | 48 | Positive step size |
| ramp_rate | input | 20 | Clocks per step (0 means 1) |
| tune_word | output | 48 | Instantaneous tuning word |

## Verification
The bench aims at the clamp points. A step that lands exactly on the span and a step that overshoots it must both settle on f_high. A design that wrapped or added unconditionally would run past the endpoint and fold back to low frequencies. The same holds for the downward side, where a borrow would flip the word to near-maximum. A rate of zero and a rate change in the middle of a count are driven on purpose. An off-by-one in the reload would show as steps one clock late, and a divide by zero would stall the sweep. Freezing in other modes, clearing in the middle of a ramp and delta rewrites between steps are mixed into a seeded random run. A design that kept stepping outside the ramp mode, or held a stale delta, would drift from the expected word.

// File: rtl/rfsk_pkg.sv
package rfsk_pkg;

    localparam int FREQ_W_DEF = 48;
    localparam int RATE_W_DEF = 20;
    localparam int MODE_W_DEF = 3;
    localparam logic [MODE_W_DEF-1:0] MODE_RAMP = 3'b010;

    typedef enum logic {
        DIR_DOWN = 1'b0,
        DIR_UP   = 1'b1
    } dir_e;

    typedef struct packed {
        logic en;
        logic clr;
        dir_e dir;
    } ramp_ctl_t;

endpackage

// File: rtl/rfsk_ctl.sv
module rfsk_ctl
    import rfsk_pkg::*;
#(
    parameter int MODE_W = MODE_W_DEF
) (
    input  logic [MODE_W-1:0] mode,
    input  logic              fsk_sel,
    input  logic              clr_acc,
    output ramp_ctl_t         ctl
);

    localparam logic [MODE_W-1:0] RAMP_CODE = MODE_W'(MODE_RAMP);

    always_comb begin
        ctl.en  = (mode == RAMP_CODE);
        ctl.clr = clr_acc;
        ctl.dir = fsk_sel ? DIR_UP : DIR_DOWN;
    end

endmodule

// File: rtl/rfsk_rate_timer.sv
module rfsk_rate_timer
    import rfsk_pkg::*;
#(
    parameter int RATE_W = RATE_W_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  ramp_ctl_t         ctl,
    input  logic [RATE_W-1:0] ramp_rate,
    output logic              step
);

    localparam logic [RATE_W-1:0] ONE = RATE_W'(1);

    logic [RATE_W-1:0] cnt_q;
    logic [RATE_W-1:0] reload;

    always_comb begin
        reload = (ramp_rate == '0) ? '0 : ramp_rate - ONE;
        step   = ctl.en && !ctl.clr && (cnt_q == '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (ctl.clr) begin
            cnt_q <= reload;
        end else if (ctl.en) begin
            if (cnt_q == '0) cnt_q <= reload;
            else             cnt_q <= cnt_q - ONE;
        end
    end

    // R4
    rate_countdown_chk: assert property (@(posedge clk) disable iff (rst)
        (ctl.en && !ctl.clr && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - ONE));

    // R4
    rate_reload_chk: assert property (@(posedge clk) disable iff (rst)
        step |=> (cnt_q == (($past(ramp_rate) == '0) ? '0 : $past(ramp_rate) - ONE)));

endmodule

// File: rtl/rfsk_freq_accum.sv
module rfsk_freq_accum
    import rfsk_pkg::*;
#(
    parameter int FREQ_W = FREQ_W_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  ramp_ctl_t         ctl,
    input  logic              step,
    input  logic [FREQ_W-1:0] span,
    input  logic [FREQ_W-1:0] delta,
    output logic [FREQ_W-1:0] acc
);

    logic [FREQ_W-1:0] acc_q;
    logic [FREQ_W-1:0] acc_up;
    logic [FREQ_W-1:0] acc_dn;
    logic              hit_top;
    logic              hit_bot;

    always_comb begin
        hit_top = (acc_q >= span) || (delta >= (span - acc_q));
        hit_bot = (delta >= acc_q);
        acc_up  = hit_top ? span : acc_q + delta;
        acc_dn  = hit_bot ? '0   : acc_q - delta;
    end

    always_ff @(posedge clk) begin
        if (rst || ctl.clr) begin
            acc_q <= '0;
        end else if (step) begin
            acc_q <= (ctl.dir == DIR_UP) ? acc_up : acc_dn;
        end
    end

    assign acc = acc_q;

    // R3
    clear_zero_chk: assert property (@(posedge clk) disable iff (rst)
        ctl.clr |=> (acc_q == '0));

    // R5
    up_step_chk: assert property (@(posedge clk) disable iff (rst)
        (step && !ctl.clr && ctl.dir == DIR_UP && acc_q < span && (span - acc_q) > delta)
        |=> (acc_q == $past(acc_q) + $past(delta)));

    // R7
    top_clamp_chk: assert property (@(posedge clk) disable iff (rst)
        (step && !ctl.clr && ctl.dir == DIR_UP && acc_q <= span && delta >= (span - acc_q))
        |=> (acc_q == $past(span)));

    // R8
    bottom_clamp_chk: assert property (@(posedge clk) disable iff (rst)
        (step && !ctl.clr && ctl.dir == DIR_DOWN && delta >= acc_q)
        |=> (acc_q == '0));

    // R6
    down_step_chk: assert property (@(posedge clk) disable iff (rst)
        (step && !ctl.clr && ctl.dir == DIR_DOWN && delta < acc_q)
        |=> (acc_q == $past(acc_q) - $past(delta)));

endmodule

// File: rtl/rfsk_sweeper.sv
module rfsk_sweeper
    import rfsk_pkg::*;
#(
    parameter int FREQ_W = FREQ_W_DEF,
    parameter int RATE_W = RATE_W_DEF,
    parameter int MODE_W = MODE_W_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [MODE_W-1:0] mode,
    input  logic              fsk_sel,
    input  logic              clr_acc,
    input  logic [FREQ_W-1:0] f_low,
    input  logic [FREQ_W-1:0] f_high,
    input  logic [FREQ_W-1:0] delta_word,
    input  logic [RATE_W-1:0] ramp_rate,
    output logic [FREQ_W-1:0] tune_word
);

    ramp_ctl_t         ctl;
    logic              step;
    logic [FREQ_W-1:0] span;
    logic [FREQ_W-1:0] acc;

    assign span = f_high - f_low;

    rfsk_ctl #(.MODE_W(MODE_W)) u_ctl (
        .mode    (mode),
        .fsk_sel (fsk_sel),
        .clr_acc (clr_acc),
        .ctl     (ctl)
    );

    rfsk_rate_timer #(.RATE_W(RATE_W)) u_timer (
        .clk       (clk),
        .rst       (rst),
        .ctl       (ctl),
        .ramp_rate (ramp_rate),
        .step      (step)
    );

    rfsk_freq_accum #(.FREQ_W(FREQ_W)) u_accum (
        .clk   (clk),
        .rst   (rst),
        .ctl   (ctl),
        .step  (step),
        .span  (span),
        .delta (delta_word),
        .acc   (acc)
    );

    assign tune_word = f_low + acc;

    // R2
    freeze_chk: assert property (@(posedge clk) disable iff (rst)
        (!ctl.en && !clr_acc) |=> $stable(acc));

    // R2
    no_step_chk: assert property (@(posedge clk) disable iff (rst)
        !ctl.en |-> !step);

endmodule

// File: tb/sim_rfsk_sweeper.sv
module sim_rfsk_sweeper;

    localparam int  CLK_PERIOD = 10;
    localparam int  FW = 48;
    localparam int  RW = 20;
    localparam logic [2:0] RAMP = 3'b010;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [2:0]    mode = RAMP;
    logic          fsk_sel = 1'b0;
    logic          clr_acc = 1'b0;
    logic [FW-1:0] f_low = '0;
    logic [FW-1:0] f_high = '0;
    logic [FW-1:0] delta_word = '0;
    logic [RW-1:0] ramp_rate = '0;
    logic [FW-1:0] tune_word;

    int checks = 0;
    int fails  = 0;
    logic [FW-1:0] m_acc = '0;
    logic [RW-1:0] m_cnt = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rfsk_sweeper u0 (
        .clk(clk), .rst(rst), .mode(mode), .fsk_sel(fsk_sel), .clr_acc(clr_acc),
        .f_low(f_low), .f_high(f_high), .delta_word(delta_word),
        .ramp_rate(ramp_rate), .tune_word(tune_word)
    );

    function automatic logic [RW-1:0] exp_reload(input logic [RW-1:0] r);
        return (r == '0) ? '0 : r - 1'b1;
    endfunction

    function automatic logic [FW-1:0] exp_next(input logic [FW-1:0] a, input logic [FW-1:0] d,
                                               input logic [FW-1:0] s, input logic up);
        if (up) return (a >= s || d >= s - a) ? s : a + d;
        return (d >= a) ? '0 : a - d;
    endfunction

    task automatic check(input string tag, input logic [FW-1:0] act, input logic [FW-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: tune_word actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic cyc(input string tag);
        @(posedge clk);
        if (rst) begin
            m_acc = '0; m_cnt = '0;
        end else if (clr_acc) begin
            m_acc = '0; m_cnt = exp_reload(ramp_rate);
        end else if (mode == RAMP) begin
            if (m_cnt == '0) begin
                m_acc = exp_next(m_acc, delta_word, f_high - f_low, fsk_sel);
                m_cnt = exp_reload(ramp_rate);
            end else begin
                m_cnt = m_cnt - 1'b1;
            end
        end
        @(negedge clk);
        check(tag, tune_word, f_low + m_acc);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        fails++;
        $display("FAIL watchdog: run actual hung expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        f_low = 48'h0000_1000_0000; f_high = 48'h0000_1000_0064;
        delta_word = 48'd30; ramp_rate = 20'd0;
        repeat (3) cyc("R1 reset");
        rst = 1'b0;
        @(negedge clk);
        check("R1 after reset", tune_word, f_low);

        // R5 / R7: rate 0, upward with overshoot at 120 -> clamp at 100
        fsk_sel = 1'b1;
        for (int i = 0; i < 8; i++) cyc("R5/R7 up ramp rate0");
        check("R7 held at f_high", tune_word, f_high);
        // R7: exact landing: delta 25 reaches span exactly
        clr_acc = 1'b1; cyc("R3 clear"); clr_acc = 1'b0;
        check("R3 cleared to f_low", tune_word, f_low);
        delta_word = 48'd25;
        for (int i = 0; i < 6; i++) cyc("R7 exact landing");
        // R6 / R8 downward
        fsk_sel = 1'b0; delta_word = 48'd40;
        for (int i = 0; i < 6; i++) cyc("R6/R8 down ramp");
        check("R8 held at f_low", tune_word, f_low);
        // R4: rate 3, then rate change mid-count (R9)
        fsk_sel = 1'b1; delta_word = 48'd7; ramp_rate = 20'd3;
        for (int i = 0; i < 10; i++) cyc("R4 rate3 spacing");
        ramp_rate = 20'd1; delta_word = 48'd2;
        for (int i = 0; i < 8; i++) cyc("R9 mid-sweep rewrite");
        // R2 freeze in other mode
        mode = 3'b001;
        for (int i = 0; i < 5; i++) cyc("R2 frozen mode001");
        // R10: f_low change shows at once
        f_low = f_low + 48'd5; f_high = f_high + 48'd5;
        #1; check("R10 f_low passthrough", tune_word, f_low + m_acc);
        clr_acc = 1'b1; cyc("R3 clear in other mode"); clr_acc = 1'b0;
        mode = RAMP;

        // random phase
        for (int blk = 0; blk < 40; blk++) begin
            logic [FW-1:0] sp;
            f_low = {$urandom, $urandom} & 48'h7FFF_FFFF_FFFF;
            sp = FW'($urandom_range(1, 60000));
            f_high = f_low + sp;
            clr_acc = 1'b1; cyc("R3 random clear"); clr_acc = 1'b0;
            for (int i = 0; i < 80; i++) begin
                if ($urandom_range(0, 9) == 0) fsk_sel = ~fsk_sel;
                if ($urandom_range(0, 7) == 0) delta_word = FW'($urandom_range(1, 20000));
                if ($urandom_range(0, 11) == 0) ramp_rate = RW'($urandom_range(0, 4));
                mode = ($urandom_range(0, 15) == 0) ? 3'b000 : RAMP;
                clr_acc = ($urandom_range(0, 63) == 0);
                cyc("R2/R4/R5/R6/R7/R8/R9 random");
            end
            mode = RAMP; clr_acc = 1'b0;
        end

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule